// File: doc/BRIEF.md
# Cascaded Three-Channel Interval Timer

This block holds three 16-bit down-counters that all run as rate generators. Channel 2 counts a 1 MHz master enable pulse and works as a prescaler. Each time it reaches its terminal count, the one-cycle pulse it produces becomes the count enable for channels 0 and 1. Each terminal count of channel 0 or channel 1 raises a one-cycle interrupt request toward the interrupt controller. Loading channel 2 with 2 gives channels 0 and 1 a 500 kHz time base.

Software reaches the block through a byte-wide register port. A control byte at address 15 either programs a channel or freezes its count. Each channel has a data port at address 4*ch+3. A new count is written to the data port as two bytes, low byte first. A count is read back from the same port, also low byte first, either from the frozen copy or from the live counter. The register port is a plain strobe interface with no back-pressure: every write or read strobe takes effect in the cycle it is sampled, and the data-port byte for the addressed channel is on `bus_rdata` combinationally.

Top module: `timer_cascade`

## Requirements
- R1: After reset every channel is stopped with count 0, both interrupt lines are low, and every data port returns the low byte on its next read.
- R2: The control register sits at address 15 and the data ports of channels 0, 1 and 2 at addresses 3, 7 and 11. A write to any other address has no effect, and `bus_rdata` is 0 at any address other than a data port.
- R3: Control byte fields are bits 7:6 for the channel, bits 5:4 for the access code, bits 3:1 for the mode and bit 0 for the BCD flag. Access 11 with mode 010 and bit 0 clear programs the channel: it stops the channel, discards a half-written count and returns the read order to the low byte. Access 00 is a latch command. Channel 3, access 01 or 10, any other mode, and BCD set are all ignored.
- R4: A count is written as the low byte and then the high byte. The low byte alone changes nothing. The high byte loads the counter and starts counting, and it takes priority over a decrement in the same cycle.
- R5: On each enable, a running channel whose count is 1 emits a pulse in that cycle and reloads its programmed value. Any other count decrements by one. A value of 0 acts as 65536, and 0xFFFF counts the full 16-bit range.
- R6: A load value of 1 is rejected. The channel stays stopped and its count is unchanged.
- R7: Channel 2 is enabled by `tick_1mhz`. Channels 0 and 1 are enabled only by channel 2's terminal pulse.
- R8: `irq_t0` and `irq_t1` go high for exactly one cycle, on the clock edge that consumes a terminal pulse of channel 0 or channel 1 respectively.
- R9: A latch command freezes the channel's count as it stood before any decrement in the same cycle. The next two reads return its low byte and then its high byte. Further latch commands are ignored until the high byte has been read.
- R10: When no latch is pending, reads return the live count, low byte first and then high byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1mhz | input | 1 | Master count enable for channel 2 |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (advances byte order) |
| bus_addr | input | 4 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read byte of the addressed data port |
| irq_t0 | output | 1 | Channel 0 terminal-count interrupt pulse |
| irq_t1 | output | 1 | Channel 1 terminal-count interrupt pulse |

## Verification
The counting chain is driven in three ways:
- **Single master ticks with no ticks between them.** Counts are then exact, which exposes off-by-one errors in the prescaler and in the latched versus live read-back.
- **Free-running ticks at a fixed divisor.** The spacing between interrupts has to equal the product of the two reload values times the divisor, which separates a correct cascade from one that clocks channels 0 and 1 directly.
- **A long run with a 0xFFFF prescale.** This checks the full-range reload.

Malformed control bytes, stray addresses, a half-written count and a load of 1 are each followed by further ticks. A wrongly accepted command then shows up as a count that is frozen or still moving.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int N_CH       = 3;
  localparam int PRESC_CH   = 2;
  localparam int ADDR_W     = 4;
  localparam int CTRL_ADDR  = 15;

  typedef enum logic [1:0] {
    ACC_FREEZE = 2'b00,
    ACC_LOONLY = 2'b01,
    ACC_HIONLY = 2'b10,
    ACC_PAIR   = 2'b11
  } access_e;

  localparam logic [2:0] MODE_RATE = 3'b010;

  function automatic int port_addr(input int ch);
    return 4 * ch + 3;
  endfunction
endpackage

// File: rtl/timer_busdec.sv
module timer_busdec
  import timer_pkg::*;
#(
  parameter int NCH   = N_CH,
  parameter int AW    = ADDR_W
) (
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [NCH-1:0] prog,
  output logic [NCH-1:0] freeze,
  output logic [NCH-1:0] wr_stb,
  output logic [NCH-1:0] rd_stb,
  output logic [NCH-1:0] hit
);
  logic    ctrl_wr;
  access_e acc;
  logic    mode_ok;

  assign ctrl_wr = wr_en && (addr == AW'(CTRL_ADDR));
  assign acc     = access_e'(wdata[5:4]);
  assign mode_ok = (wdata[3:1] == MODE_RATE) && !wdata[0];

  for (genvar ch = 0; ch < NCH; ch++) begin : g_dec
    logic sel;
    assign sel         = ctrl_wr && (wdata[7:6] == 2'(ch));
    assign prog[ch]    = sel && (acc == ACC_PAIR) && mode_ok;
    assign freeze[ch]  = sel && (acc == ACC_FREEZE);
    assign hit[ch]     = (addr == AW'(port_addr(ch)));
    assign wr_stb[ch]  = wr_en && hit[ch];
    assign rd_stb[ch]  = rd_en && hit[ch];
  end
endmodule

// File: rtl/timer_chan.sv
module timer_chan #(
  parameter int BYTE_W = 8,
  localparam int CW    = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              prog,
  input  logic              freeze,
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              tc_pulse
);
  logic              running;
  logic [CW-1:0]     count;
  logic [CW-1:0]     reload;
  logic [BYTE_W-1:0] lo_hold;
  logic              lo_seen;
  logic              frz_v;
  logic [CW-1:0]     frz_q;
  logic              rd_hi;
  logic [CW-1:0]     new_word;
  logic              unit_load;
  logic [CW-1:0]     rd_src;

  assign new_word  = {wdata, lo_hold};
  assign unit_load = (new_word == CW'(1));
  assign tc_pulse  = running && tick_en && (count == CW'(1));
  assign rd_src    = frz_v ? frz_q : count;
  assign rd_byte   = rd_hi ? rd_src[CW-1:BYTE_W] : rd_src[BYTE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      count   <= '0;
      reload  <= '0;
      lo_hold <= '0;
      lo_seen <= 1'b0;
      frz_v   <= 1'b0;
      frz_q   <= '0;
      rd_hi   <= 1'b0;
    end else begin
      if (running && tick_en)
        count <= (count == CW'(1)) ? reload : count - CW'(1);

      if (prog) begin
        running <= 1'b0;
        lo_seen <= 1'b0;
        rd_hi   <= 1'b0;
        frz_v   <= 1'b0;
      end else if (wr_stb) begin
        if (!lo_seen) begin
          lo_hold <= wdata;
          lo_seen <= 1'b1;
        end else begin
          lo_seen <= 1'b0;
          reload  <= new_word;
          if (unit_load) begin
            running <= 1'b0;
          end else begin
            count   <= new_word;
            running <= 1'b1;
          end
        end
      end

      if (freeze && !frz_v) begin
        frz_q <= count;
        frz_v <= 1'b1;
        rd_hi <= 1'b0;
      end

      if (rd_stb) begin
        if (rd_hi) begin
          rd_hi <= 1'b0;
          frz_v <= 1'b0;
        end else begin
          rd_hi <= 1'b1;
        end
      end
    end
  end

  AST_RELOAD_AT_TC: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick_en && count == CW'(1) && !(wr_stb && lo_seen)) |=> (count == $past(reload))); // R5
  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick_en && count != CW'(1) && !(wr_stb && lo_seen)) |=> (count == $past(count) - CW'(1))); // R5
  AST_NO_UNIT_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (reload != CW'(1))); // R6
  AST_PROG_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    prog |=> !running); // R3
  AST_FROZEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_v && !prog) |=> $stable(frz_q)); // R9
  AST_HI_READ_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && rd_hi && !freeze) |=> !frz_v); // R9
endmodule

// File: rtl/timer_cascade.sv
module timer_cascade
  import timer_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int AW     = ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1mhz,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [AW-1:0]     bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              irq_t0,
  output logic              irq_t1
);
  logic [N_CH-1:0]             prog, freeze, wr_stb, rd_stb, hit;
  logic [N_CH-1:0]             pulse, tick_in;
  logic [N_CH-1:0][BYTE_W-1:0] ch_byte;

  timer_busdec #(.NCH(N_CH), .AW(AW)) u_dec (
    .wr_en (bus_wr),
    .rd_en (bus_rd),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .prog  (prog),
    .freeze(freeze),
    .wr_stb(wr_stb),
    .rd_stb(rd_stb),
    .hit   (hit)
  );

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    if (ch == PRESC_CH) begin : g_pre
      assign tick_in[ch] = tick_1mhz;
    end else begin : g_sub
      assign tick_in[ch] = pulse[PRESC_CH];
    end
    timer_chan #(.BYTE_W(BYTE_W)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_in[ch]),
      .prog    (prog[ch]),
      .freeze  (freeze[ch]),
      .wr_stb  (wr_stb[ch]),
      .rd_stb  (rd_stb[ch]),
      .wdata   (bus_wdata),
      .rd_byte (ch_byte[ch]),
      .tc_pulse(pulse[ch])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int c = 0; c < N_CH; c++)
      if (hit[c]) bus_rdata = ch_byte[c];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_t0 <= 1'b0;
      irq_t1 <= 1'b0;
    end else begin
      irq_t0 <= pulse[0];
      irq_t1 <= pulse[1];
    end
  end

  AST_IRQ0_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_t0 |=> !irq_t0); // R8
  AST_IRQ1_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_t1 |=> !irq_t1); // R8
  AST_SUB_NEEDS_PRESCALE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_t0 || irq_t1) |-> $past(pulse[PRESC_CH])); // R7
endmodule

// File: tb/sim_timer_cascade.sv
`timescale 1ns/1ps
module sim_timer_cascade;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       bus_wr = 0, bus_rd = 0;
  logic [3:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic       auto_tick = 0, force_tick = 0;
  wire        tick_w = auto_tick | force_tick;
  wire  [7:0] bus_rdata;
  wire        irq_t0, irq_t1;

  int checks = 0, errors = 0;
  int tdiv = 0, tcnt = 0;
  int cyc = 0;
  int r0_n = 0, r0_last = 0, r0_prev = 0, r1_n = 0, r1_last = 0, r1_prev = 0;
  bit wide = 0, p_irq0 = 0, p_irq1 = 0;
  bit done = 0;

  always #5 clk = ~clk;

  timer_cascade u0 (
    .clk(clk), .rst_n(rst_n), .tick_1mhz(tick_w),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_t0(irq_t0), .irq_t1(irq_t1)
  );

  // behavioural reference model
  int m_cnt[3], m_rel[3], m_lo[3], m_lat[3], oc[3];
  bit m_run[3], m_los[3], m_latv[3], m_rdhi[3];
  bit m_irq0, m_irq1, p0, p1, p2, tk;
  int c_sel, acc, w;

  function automatic int m_rbyte(input int a);
    int v;
    for (int c = 0; c < 3; c++)
      if (a == 4 * c + 3) begin
        v = m_latv[c] ? m_lat[c] : m_cnt[c];
        return m_rdhi[c] ? (v >> 8) & 255 : v & 255;
      end
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 3; c++) begin
        m_cnt[c] = 0; m_rel[c] = 0; m_lo[c] = 0; m_lat[c] = 0;
        m_run[c] = 0; m_los[c] = 0; m_latv[c] = 0; m_rdhi[c] = 0;
      end
      m_irq0 = 0; m_irq1 = 0;
    end else begin
      p2 = m_run[2] && tick_w && m_cnt[2] == 1;
      p0 = m_run[0] && p2 && m_cnt[0] == 1;
      p1 = m_run[1] && p2 && m_cnt[1] == 1;
      for (int c = 0; c < 3; c++) begin
        oc[c] = m_cnt[c];
        tk = (c == 2) ? tick_w : p2;
        if (m_run[c] && tk) m_cnt[c] = (oc[c] == 1) ? m_rel[c] : (oc[c] - 1) & 16'hFFFF;
      end
      if (bus_wr && bus_addr == 15) begin
        c_sel = bus_wdata >> 6; acc = (bus_wdata >> 4) & 3;
        if (c_sel < 3) begin
          if (acc == 3 && ((bus_wdata >> 1) & 7) == 2 && bus_wdata[0] == 0) begin
            m_run[c_sel] = 0; m_los[c_sel] = 0; m_rdhi[c_sel] = 0; m_latv[c_sel] = 0;
          end else if (acc == 0 && !m_latv[c_sel]) begin
            m_lat[c_sel] = oc[c_sel]; m_latv[c_sel] = 1; m_rdhi[c_sel] = 0;
          end
        end
      end
      for (int c = 0; c < 3; c++) begin
        if (bus_wr && bus_addr == 4 * c + 3) begin
          if (!m_los[c]) begin m_lo[c] = bus_wdata; m_los[c] = 1; end
          else begin
            m_los[c] = 0; w = bus_wdata * 256 + m_lo[c]; m_rel[c] = w;
            if (w != 1) begin m_cnt[c] = w; m_run[c] = 1; end else m_run[c] = 0;
          end
        end
        if (bus_rd && bus_addr == 4 * c + 3) begin
          if (m_rdhi[c]) begin m_rdhi[c] = 0; m_latv[c] = 0; end else m_rdhi[c] = 1;
        end
      end
      m_irq0 = p0; m_irq1 = p1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // cycle-by-cycle comparison and interrupt timing monitor
  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      chk(irq_t0 === m_irq0 && irq_t1 === m_irq1 && bus_rdata === 8'(m_rbyte(bus_addr)),
          "R5/R7/R8/R10 model", {irq_t0, irq_t1, bus_rdata}, {m_irq0, m_irq1, 8'(m_rbyte(bus_addr))});
      if (irq_t0 && !p_irq0) begin r0_prev = r0_last; r0_last = cyc; r0_n++; end
      if (irq_t1 && !p_irq1) begin r1_prev = r1_last; r1_last = cyc; r1_n++; end
      if ((irq_t0 && p_irq0) || (irq_t1 && p_irq1)) wide = 1;
      p_irq0 = irq_t0; p_irq1 = irq_t1;
    end
  end

  always @(negedge clk) begin
    #1;
    if (tdiv > 0) begin
      auto_tick = (tcnt == tdiv - 1);
      tcnt = (tcnt + 1) % tdiv;
    end else begin
      auto_tick = 0; tcnt = 0;
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk); #1;
    bus_addr = 4'(a); bus_wdata = 8'(d); bus_wr = 1;
    @(negedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk); #1;
    bus_addr = 4'(a); bus_rd = 1;
    #1 v = bus_rdata;
    @(negedge clk); #1;
    bus_rd = 0;
  endtask

  task automatic rd16(input int a, output int v);
    int lo, hi;
    rd(a, lo); rd(a, hi);
    v = hi * 256 + lo;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1; force_tick = 1;
    end
    @(negedge clk); #1; force_tick = 0;
  endtask

  task automatic load(input int ch, input int val);
    wr(15, ch * 64 + 8'h34);
    wr(4 * ch + 3, val & 255);
    wr(4 * ch + 3, val >> 8);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    int v;
    repeat (4) @(negedge clk);
    #1 rst_n = 1;
    @(negedge clk); #2;
    chk(irq_t0 == 0 && irq_t1 == 0, "R1 irq low", {irq_t0, irq_t1}, 0);
    rd16(3, v);  chk(v == 0, "R1 ch0 reset count", v, 0);
    rd16(11, v); chk(v == 0, "R1 ch2 reset count", v, 0);
    rd(5, v);    chk(v == 0, "R2 stray address reads 0", v, 0);

    load(0, 1000);
    ticks(4);
    rd16(3, v); chk(v == 1000, "R7 ch0 idle without prescaler", v, 1000);

    load(2, 2);
    ticks(6);
    wr(15, 8'h00);
    ticks(10);
    wr(15, 8'h00);
    rd16(3, v); chk(v == 997, "R9 latched value", v, 997);
    rd16(3, v); chk(v == 992, "R10 live read after latch", v, 992);

    wr(15, 8'h34); wr(3, 8'h10);
    ticks(8);
    rd16(3, v); chk(v == 992, "R4 low byte alone holds", v, 992);
    wr(3, 8'h00);
    ticks(4);
    rd16(3, v); chk(v == 14, "R4 count after high byte", v, 14);

    wr(15, 8'h14);
    wr(14, 8'h34);
    ticks(2);
    rd16(3, v); chk(v == 13, "R2/R3 bad access and address ignored", v, 13);
    wr(15, 8'hF4); wr(15, 8'h36); wr(15, 8'h35);
    ticks(2);
    rd16(3, v); chk(v == 12, "R3 channel3/mode/bcd ignored", v, 12);

    load(0, 1);
    ticks(6);
    rd16(3, v); chk(v == 12, "R6 load of 1 rejected", v, 12);

    load(0, 5); load(1, 3); load(2, 2);
    r0_n = 0; r1_n = 0; wide = 0;
    tdiv = 5;
    for (int i = 0; i < 2000 && (r0_n < 3 || r1_n < 3); i++) @(negedge clk);
    tdiv = 0;
    chk(r0_last - r0_prev == 50, "R7 irq0 spacing", r0_last - r0_prev, 50);
    chk(r1_last - r1_prev == 30, "R7 irq1 spacing", r1_last - r1_prev, 30);
    chk(wide == 0, "R8 one-cycle irq", wide, 0);
    repeat (4) @(negedge clk);

    wr(15, 8'hB4);
    load(0, 2);
    wr(11, 8'hFF); wr(11, 8'hFF);
    ticks(65534);
    rd16(3, v);  chk(v == 2, "R5 ch0 before full prescale", v, 2);
    rd16(11, v); chk(v == 1, "R5 ch2 at terminal", v, 1);
    ticks(1);
    rd16(3, v);  chk(v == 1, "R5 ch0 after full prescale", v, 1);
    rd16(11, v); chk(v == 16'hFFFF, "R5 ch2 full range reload", v, 16'hFFFF);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule